// File: doc/BRIEF.md
# Bus Write Drain Status Sequencer

This block produces three status flags that tell software how far a burst of bus writes has moved through a write queue. It does not hold any data. A one-cycle write strobe marks each bus write. From that strobe the block runs a fixed timing pattern measured in clock cycles. The intake flag (bit 5) is high while the write is being accepted. The middle flag (bit 4) is high while the write is in flight. The output flag (bit 0) is high while the write is being delivered.

Each flag has its own rise deadline and fall deadline, and each deadline is a saturating down-counter. When a write arrives while a fall deadline is still pending, that deadline moves later by the flag's full high time. A rise deadline that is still pending keeps its time. A deadline that has already expired is scheduled again, measured from the current write.

The flags are read through a small combinational register port. The status word sits at one address and holds the flags at bits 5, 4 and 0. All other bits of that word read zero, and every other address reads zero.

Top module: `wfifo_status_seq`

## Requirements
- R1: The cycle after a write strobe, bit 5 reads 1. It then stays 1 for at least HI_IN cycles (default 4).
- R2: After a lone write at edge T, bit 5 clears at edge T+HI_IN. Bit 4 sets at that same edge.
- R3: After a lone write at edge T, bit 4 clears at edge T+HI_IN+HI_MID (default 4+8). Bit 0 sets at edge T+RISE_OUT (default 12).
- R4: After a lone write at edge T, bit 0 clears at edge T+RISE_OUT+HI_OUT (default 12+12).
- R5: A write at edge W, while a flag's fall deadline D satisfies D ≥ W, moves that deadline to D plus the flag's high time. A flag never clears at the edge of a write.
- R6: A write at edge W, while a rise deadline R satisfies R ≥ W, leaves R unchanged.
- R7: A write at edge W, when a rise deadline is already past (R < W), sets that deadline to W plus the flag's rise delay. The rise delay is HI_IN for bit 4 and RISE_OUT for bit 0.
- R8: A write at edge W, when a fall deadline is already past, sets it to that flag's current rise deadline plus its high time. For bit 5 the rise deadline is W itself.
- R9: No deadline is ever placed more than 2^CW−1 cycles after the current edge (default 255). A farther deadline saturates at that limit instead of wrapping.
- R10: When rd_addr equals STATUS_ADDR (default 2), rd_data carries bit 5, bit 4 and bit 0 in the same cycle, with all other bits zero. Any other address reads all zeros.
- R11: Synchronous reset clears all three flags and cancels all pending deadlines. After reset no flag sets until a new write arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_strobe | input | 1 | One-cycle pulse per bus write |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |

## Verification
A wrong counter load or a missed extension shows at the port within one deadline of the write. The flag that changes at the wrong edge is visible at the first sample after that edge. The bench compares every cycle of every scenario against a model built on absolute deadlines, so a one-cycle slip is caught at once. The scenarios cover write pairs at every gap from 1 to 30 cycles, a grid of three-write patterns, and a long back-to-back burst that drives the fall deadlines to their saturation limit. Together these exercise every branch: pending versus expired, and rise versus fall.

// File: rtl/wfs_pkg.sv
`timescale 1ns/1ps
package wfs_pkg;

    // How a deadline counter treats a write that arrives while it is still counting.
    typedef enum logic {
        DL_HOLD   = 1'b0,   // keep the pending deadline where it is
        DL_EXTEND = 1'b1    // push the pending deadline later by one full step
    } dl_mode_e;

    localparam int LANES = 3;

    // Positions in the status word; software decodes these bits.
    localparam int POS_IN  = 5;
    localparam int POS_MID = 4;
    localparam int POS_OUT = 0;

    typedef struct packed {
        logic stage_in;
        logic stage_mid;
        logic stage_out;
    } drain_stat_t;

endpackage

// File: rtl/wfs_deadline.sv
`timescale 1ns/1ps
// One deadline, held as the number of edges left until it fires (0 = idle).
module wfs_deadline
    import wfs_pkg::*;
#(
    parameter int          CW   = 8,
    parameter dl_mode_e    MODE = DL_HOLD,
    parameter int unsigned STEP = 4
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [CW-1:0] fresh,
    output logic [CW-1:0] cnt
);
    localparam logic [CW:0] STEP_X  = (CW+1)'(STEP);
    localparam bit          EXTENDS = (MODE == DL_EXTEND);

    logic [CW-1:0] cnt_d;
    logic [CW-1:0] dec;
    logic [CW:0]   ext_sum;
    logic [CW-1:0] ext_val;
    logic          busy;

    assign busy    = (cnt != '0);
    assign dec     = cnt - CW'(1);
    assign ext_sum = {1'b0, dec} + STEP_X;
    assign ext_val = ext_sum[CW] ? '1 : ext_sum[CW-1:0];

    always_comb begin
        cnt_d = cnt;
        if (trig && busy && EXTENDS) begin
            cnt_d = ext_val;
        end else if (busy) begin
            cnt_d = dec;
        end else if (trig) begin
            cnt_d = fresh;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end
endmodule

// File: rtl/wfs_lane.sv
`timescale 1ns/1ps
// One status flag: an optional rise deadline followed by an extendable fall deadline.
module wfs_lane
    import wfs_pkg::*;
#(
    parameter int          CW       = 8,
    parameter bit          HAS_RISE = 1'b1,
    parameter int unsigned RISE_DLY = 4,
    parameter int unsigned HIGH_LEN = 8
)(
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic level
);
    logic          set_ev;
    logic          clr_ev;
    logic [CW-1:0] base_off;
    logic [CW:0]   fall_sum;
    logic [CW-1:0] fall_fresh;
    logic [CW-1:0] fall_cnt;

    generate
        if (HAS_RISE) begin : g_rise
            logic [CW-1:0] rise_cnt;
            wfs_deadline #(.CW(CW), .MODE(DL_HOLD), .STEP(RISE_DLY)) u_rise (
                .clk   (clk),
                .rst   (rst),
                .trig  (trig),
                .fresh (CW'(RISE_DLY)),
                .cnt   (rise_cnt)
            );
            // The rise is never moved by a write, so it fires whenever it reaches 1.
            assign set_ev   = (rise_cnt == CW'(1));
            assign base_off = (rise_cnt != '0) ? (rise_cnt - CW'(1)) : CW'(RISE_DLY);
        end else begin : g_direct
            assign set_ev   = trig;
            assign base_off = '0;
        end
    endgenerate

    // A fresh fall is measured from this flag's rise deadline.
    assign fall_sum   = {1'b0, base_off} + (CW+1)'(HIGH_LEN);
    assign fall_fresh = fall_sum[CW] ? '1 : fall_sum[CW-1:0];

    wfs_deadline #(.CW(CW), .MODE(DL_EXTEND), .STEP(HIGH_LEN)) u_fall (
        .clk   (clk),
        .rst   (rst),
        .trig  (trig),
        .fresh (fall_fresh),
        .cnt   (fall_cnt)
    );

    // A write in the same cycle extends the fall, so the fall does not fire then.
    assign clr_ev = (fall_cnt == CW'(1)) && !trig;

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= 1'b0;
        end else begin
            // The fall is applied after the rise.
            if (set_ev) level <= 1'b1;
            if (clr_ev) level <= 1'b0;
        end
    end
endmodule

// File: rtl/wfs_regread.sv
`timescale 1ns/1ps
module wfs_regread
    import wfs_pkg::*;
#(
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned STATUS_ADDR = 2
)(
    input  logic [ADDR_W-1:0] rd_addr,
    input  drain_stat_t       st,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [ADDR_W-1:0] HIT = ADDR_W'(STATUS_ADDR);

    always_comb begin
        rd_data = '0;
        if (rd_addr == HIT) begin
            rd_data[POS_IN]  = st.stage_in;
            rd_data[POS_MID] = st.stage_mid;
            rd_data[POS_OUT] = st.stage_out;
        end
    end
endmodule

// File: rtl/wfifo_status_seq.sv
`timescale 1ns/1ps
module wfifo_status_seq
    import wfs_pkg::*;
#(
    parameter int          CW          = 8,
    parameter int unsigned HI_IN       = 4,
    parameter int unsigned HI_MID      = 8,
    parameter int unsigned HI_OUT      = 12,
    parameter int unsigned RISE_OUT    = 12,
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned STATUS_ADDR = 2
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_strobe,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    // Lane 0 drives bit 5, lane 1 drives bit 4, lane 2 drives bit 0.
    localparam int unsigned LANE_RISE [LANES] = '{0, HI_IN, RISE_OUT};
    localparam int unsigned LANE_HIGH [LANES] = '{HI_IN, HI_MID, HI_OUT};

    logic [LANES-1:0] lane_lvl;
    drain_stat_t      st;

    generate
        for (genvar g = 0; g < LANES; g++) begin : g_lane
            wfs_lane #(
                .CW       (CW),
                .HAS_RISE (g != 0),
                .RISE_DLY (LANE_RISE[g]),
                .HIGH_LEN (LANE_HIGH[g])
            ) u_lane (
                .clk   (clk),
                .rst   (rst),
                .trig  (wr_strobe),
                .level (lane_lvl[g])
            );
        end
    endgenerate

    assign st.stage_in  = lane_lvl[0];
    assign st.stage_mid = lane_lvl[1];
    assign st.stage_out = lane_lvl[2];

    wfs_regread #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .STATUS_ADDR (STATUS_ADDR)
    ) u_read (
        .rd_addr (rd_addr),
        .st      (st),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/wfs_chk.sv
`timescale 1ns/1ps
module wfs_chk #(
    parameter int unsigned HI_IN       = 4,
    parameter int          ADDR_W      = 4,
    parameter int          DATA_W      = 32,
    parameter int unsigned STATUS_ADDR = 2
)(
    input logic              clk,
    input logic              rst,
    input logic              wr_strobe,
    input logic [2:0]        lvl,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    localparam logic [DATA_W-1:0] FLAG_MASK =
        (DATA_W'(1) << 5) | (DATA_W'(1) << 4) | DATA_W'(1);

    logic        seen;
    int unsigned since;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen  <= 1'b0;
            since <= 0;
        end else if (wr_strobe) begin
            seen  <= 1'b1;
            since <= 0;
        end else if (since < HI_IN) begin
            since <= since + 1;
        end
    end

    AST_IN_SET_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_strobe |=> lvl[0]); // R1
    AST_IN_MIN_HIGH: assert property (@(posedge clk) disable iff (rst)
        (seen && since < HI_IN) |-> lvl[0]); // R1
    AST_NO_CLEAR_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        $fell(lvl[0]) |-> !$past(wr_strobe)); // R5
    AST_QUIET_BEFORE_WRITE: assert property (@(posedge clk) disable iff (rst)
        !seen |-> (lvl == 3'b000)); // R11
    AST_OTHER_ADDR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr != ADDR_W'(STATUS_ADDR)) |-> (rd_data == '0)); // R10
    AST_SPARE_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == ADDR_W'(STATUS_ADDR)) |-> ((rd_data & ~FLAG_MASK) == '0)); // R10
endmodule

bind wfifo_status_seq wfs_chk #(
    .HI_IN       (HI_IN),
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .STATUS_ADDR (STATUS_ADDR)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_strobe (wr_strobe),
    .lvl       (lane_lvl),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data)
);

// File: tb/wfifo_status_seq_bench.sv
`timescale 1ns/1ps
module wfifo_status_seq_bench;
    localparam int HI5   = 4;
    localparam int HI4   = 8;
    localparam int HI0   = 12;
    localparam int RISE0 = 12;
    localparam int MAXC  = 255;
    localparam logic [3:0] STAT_A = 4'd2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_strobe = 1'b0;
    logic [3:0]  rd_addr = STAT_A;
    logic [31:0] rd_data;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Model state: absolute edge numbers of each deadline, -1 when idle.
    int d5f, d4r, d4f, d0r, d0f;
    bit m5, m4, m0;
    int pa, pb, pc, pburst;

    always #2.5 clk = ~clk;

    wfifo_status_seq u_wfifo_status_seq (
        .clk       (clk),
        .rst       (rst),
        .wr_strobe (wr_strobe),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    function automatic int imin(int a, int b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [31:0] word(bit b5, bit b4, bit b0);
        return (32'(b5) << 5) | (32'(b4) << 4) | 32'(b0);
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rd_data=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        d5f = -1; d4r = -1; d4f = -1; d0r = -1; d0f = -1;
        m5 = 0; m4 = 0; m0 = 0;
    endtask

    // Applies a write (if any) at edge t, then the events that fall due at t.
    task automatic model_step(int t, bit w);
        if (w) begin
            m5 = 1;
            d5f = (d5f >= t) ? imin(d5f + HI5, t + MAXC) : imin(t + HI5, t + MAXC);
            if (d4r < t) d4r = t + HI5;
            d4f = (d4f >= t) ? imin(d4f + HI4, t + MAXC) : imin(d4r + HI4, t + MAXC);
            if (d0r < t) d0r = t + RISE0;
            d0f = (d0f >= t) ? imin(d0f + HI0, t + MAXC) : imin(d0r + HI0, t + MAXC);
        end
        if (d5f == t) m5 = 0;
        if (d4r == t) m4 = 1;
        if (d4f == t) m4 = 0;
        if (d0r == t) m0 = 1;
        if (d0f == t) m0 = 0;
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; wr_strobe = 1'b0; rd_addr = STAT_A;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        model_reset();
    endtask

    function automatic bit is_wr(int c);
        return (c == pa) || (c == pb) || (c == pc) || (c < pburst);
    endfunction

    // kind: 0 lone write, 1 pair, 2 triple, 3 burst
    task automatic run_case(int kind, int a, int b, int c, int burst);
        int last;
        string tag;
        pa = a; pb = b; pc = c; pburst = burst;
        apply_reset();
        last = a;
        if (b > last) last = b;
        if (c > last) last = c;
        if (burst - 1 > last) last = burst - 1;
        for (int cyc = 0; cyc < last + 300; cyc++) begin
            @(negedge clk);
            case (kind)
                0: begin
                    if (cyc - 1 - a == 0)          tag = "R1";
                    else if (cyc - 1 - a <= HI5)   tag = "R2";
                    else if (cyc - 1 - a <= RISE0) tag = "R3";
                    else                           tag = "R4";
                end
                1: begin
                    if (b - a < HI5)              tag = "R6";
                    else if (b - a < RISE0 + HI0) tag = "R5";
                    else                          tag = "R7/R8";
                end
                2: tag = "R5";
                default: tag = "R9";
            endcase
            chk(tag, rd_data, word(m5, m4, m0));
            wr_strobe = is_wr(cyc);
            model_step(cyc, is_wr(cyc));
        end
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        model_reset();
        pa = -1; pb = -1; pc = -1; pburst = 0;
        apply_reset();
        @(negedge clk);
        chk("R11", rd_data, 32'h0);

        // Lone write: R1..R4 timeline
        run_case(0, 2, -1, -1, 0);

        // Pairs at every gap (R5, R6, R7, R8)
        for (int g = 1; g <= 30; g++) run_case(1, 2, 2 + g, -1, 0);

        // Three-write grid (R5)
        foreach (pa_list[i]) begin
            foreach (pc_list[j]) run_case(2, 1, 1 + pa_list[i], 1 + pa_list[i] + pc_list[j], 0);
        end

        // Long burst pushes fall deadlines to saturation (R9)
        run_case(3, -1, -1, -1, 40);

        // R10: address decode while bit 4 alone is high
        apply_reset();
        @(negedge clk); wr_strobe = 1'b1;
        @(negedge clk); wr_strobe = 1'b0;
        repeat (5) @(negedge clk);
        chk("R10", rd_data, word(0, 1, 0));
        for (int a = 0; a < 16; a++) begin
            if (a != int'(STAT_A)) begin
                rd_addr = 4'(a);
                #1;
                chk("R10", rd_data, 32'h0);
            end
        end
        rd_addr = STAT_A;
        #1;
        chk("R10", rd_data, word(0, 1, 0));

        // R11: reset in the middle of activity cancels everything
        @(negedge clk); wr_strobe = 1'b1;
        @(negedge clk); wr_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk("R11", rd_data, 32'h0);
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            chk("R11", rd_data, 32'h0);
        end

        finish_run();
    end

    int pa_list [5] = '{1, 3, 5, 9, 13};
    int pc_list [5] = '{1, 4, 8, 12, 20};
endmodule